// File: doc/BRIEF.md
# Remote Terminal Message Memory Sequencer

This block sits between the word-level protocol engine of a serial-bus remote terminal and a shared buffer memory. When the engine presents a validated command word, the sequencer carries out the memory side of the message through an active-low request and grant handshake. A receive message stores each decoded data word, then asks the encoder to send the terminal status word, then stores a transfer status word. A transmit message asks for the status word first, then fetches each data word from memory and hands it to the encoder, then stores the transfer status word. Transfers from one terminal to another are not handled.

The memory address comes straight from the command fields. A data word lives at `{transmit bit, subaddress, word index}`. The command word copy and the transfer status word both go to the message base `{transmit bit, subaddress, 0}` and are told apart only by the operation tag. Subaddresses 0 and 31 mark mode commands. Two of them carry a data word: transmit-vector and synchronize-with-data. These either use memory at the base of the mode subaddress (vector read from 400h or 7E0h, sync word written to 000h or 3E0h) or, with external mode data off, take the vector from an input port and drop the sync word. A grant that does not come within a programmable number of cycles aborts the message and raises a timeout flag.

Top module: `rt_mem_sequencer`

## Requirements
- R1: After reset, memReqN is 1, and statusReq, wordReq, msgDone and memTimeout are 0.
- R2: On a receive data command, each word delivered by rxWordValid is written once at address `{0, subaddress, index}`, with memWrite=1, memOp=00 and the word on memWData. memReqN returns high in the cycle after the grant is sampled low.
- R3: On a receive data command, statusReq is raised only after the last data word is written. The transfer status word is written after the encoder acknowledges with encDone. statusReq, wordReq and a low memReqN are never active together.
- R4: On a transmit data command, statusReq comes first. Then, for each word, the block reads address `{1, subaddress, index}` with memWrite=0 and memOp=00, and holds the value read on txData while wordReq is high, until encDone. A word count field of 0 means 32 words.
- R5: With writeCmd=1, the command word is written before any other action at the message base `{tx bit, subaddress, 00000}` with memOp=01. The transfer status word goes to the same address with memOp=10.
- R6: With writeTsw=0, no transfer status write takes place.
- R7: Transmit-vector mode (tx bit 1, mode code 16): with extModeData=0, vectorIn is sent after the status and memory is not read. With extModeData=1, the vector is read from `{1, subaddress, 00000}` (400h or 7E0h).
- R8: Synchronize-with-data mode (tx bit 0, mode code 17): with extModeData=0, the received word is discarded with no memory write. With extModeData=1, it is written to `{0, subaddress, 00000}` (000h or 3E0h) before the status is sent.
- R9: For a mode command flagged by modeIllegal, statusMsgErr is 1 during statusReq and no data word is moved. The transfer status word has bit 9 set and bit 14 clear.
- R10: If the grant stays high for timeoutLimit consecutive request cycles, memReqN rises, memTimeout becomes 1 together with msgDone, and nothing further happens for that message. memTimeout clears when the next command is accepted.
- R11: cmdStart is ignored while a message is in progress.
- R12: modeIllegal has no effect on data (non-mode) commands.
- R13: Transfer status word layout: bit 15 = 1, bit 14 = no error, bit 9 = illegal mode command, bits 4:0 = count, other bits 0. The count is the number of words moved for data messages (32 reads as 0) and the mode code for mode messages.
- R14: While a request is pending without a grant, memAddr, memOp and memWrite stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdStart | input | 1 | One-cycle pulse: validated command word present |
| cmdWord | input | 16 | Command word: [10] tx bit, [9:5] subaddress, [4:0] word count or mode code |
| modeIllegal | input | 1 | Validator flag: mode command is illegal |
| writeCmd | input | 1 | Enable writing the command word to memory |
| writeTsw | input | 1 | Enable writing the transfer status word |
| extModeData | input | 1 | Route vector and sync words through memory |
| vectorIn | input | 16 | Vector word used when extModeData is 0 |
| timeoutLimit | input | 16 | Maximum grant wait in cycles (at least 1) |
| rxWordValid | input | 1 | One-cycle pulse: decoded word on rxWord |
| rxWord | input | 16 | Decoded data word |
| encDone | input | 1 | Encoder pulse: requested word has been sent |
| statusReq | output | 1 | Request to send the terminal status word |
| statusMsgErr | output | 1 | Message error bit for the status word |
| wordReq | output | 1 | Request to send txData |
| txData | output | 16 | Data word for the encoder |
| memReqN | output | 1 | Active-low memory request |
| memGntN | input | 1 | Active-low memory grant |
| memAddr | output | 11 | Memory word address |
| memWrite | output | 1 | 1 write, 0 read |
| memOp | output | 2 | Operation tag: 00 data, 01 command word, 10 transfer status |
| memWData | output | 16 | Write data |
| memRData | input | 16 | Read data, valid while the grant is low |
| msgDone | output | 1 | One-cycle pulse: message finished or aborted |
| memTimeout | output | 1 | Grant timeout flag for the last message |

## Verification
Suppose the word index is off by one. Then on the first granted access the address low bits move away from the expected index, and the message ends one access early or late. The error shows in the memory log within one word time. If the sequencer is in the wrong state, its effects appear at the ports at the next access or encoder request: the status request arrives before the last receive write, a mode vector is read while external mode data is off, or a discarded sync word gets written. A wrong wait counter changes the number of cycles the request stays low before a timeout, and the bench counts those cycles exactly. A broken transfer-status build shows up in the final write's data field.

// File: rtl/rtms_pkg.sv
package rtms_pkg;

  typedef enum logic [1:0] {
    OP_DATA = 2'b00,
    OP_CMD  = 2'b01,
    OP_TSW  = 2'b10
  } memOp_e;

  typedef struct packed {
    logic   latchCmd;
    logic   latchRx;
    logic   latchRd;
    logic   loadVector;
    logic   incIdx;
    logic   clrWait;
    logic   incWait;
    logic   setTmo;
    memOp_e accOp;
  } ctrlStrobes_t;

endpackage

// File: rtl/rtms_datapath.sv
module rtms_datapath
  import rtms_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int SA_W      = 5,
  parameter int WC_W      = 5,
  parameter int TMO_W     = 16,
  parameter int MC_VECTOR = 16,
  parameter int MC_SYNC   = 17,
  localparam int ADDR_W   = 1 + SA_W + WC_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      stb,
  input  logic [DATA_W-1:0] cmdWord,
  input  logic              modeIllegal,
  input  logic [DATA_W-1:0] vectorIn,
  input  logic [TMO_W-1:0]  timeoutLimit,
  input  logic [DATA_W-1:0] rxWord,
  input  logic [DATA_W-1:0] memRData,
  output logic              isTx,
  output logic              isMode,
  output logic              isVector,
  output logic              isSync,
  output logic              msgErr,
  output logic              lastWord,
  output logic              waitExpired,
  output logic              tmoFlag,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWData,
  output logic [DATA_W-1:0] txData
);

  localparam int TX_BIT      = SA_W + WC_W;
  localparam int TSW_ERR_BIT = 9;
  localparam logic [WC_W:0] FULL_COUNT = (WC_W+1)'(1) << WC_W;

  logic [DATA_W-1:0] cmdReg;
  logic              illegalReg;
  logic [DATA_W-1:0] rxReg;
  logic [DATA_W-1:0] txReg;
  logic [WC_W:0]     idx;
  logic [TMO_W-1:0]  waitCnt;
  logic              tmoReg;

  logic [SA_W-1:0]   subAddr;
  logic [WC_W-1:0]   wcField;
  logic [WC_W:0]     total;
  logic [WC_W-1:0]   countField;
  logic [DATA_W-1:0] tswWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdReg     <= '0;
      illegalReg <= 1'b0;
      rxReg      <= '0;
      txReg      <= '0;
      idx        <= '0;
      waitCnt    <= '0;
      tmoReg     <= 1'b0;
    end else begin
      if (stb.latchCmd) begin
        cmdReg     <= cmdWord;
        illegalReg <= modeIllegal;
        idx        <= '0;
        tmoReg     <= 1'b0;
      end else begin
        if (stb.incIdx) idx <= idx + (WC_W+1)'(1);
        if (stb.setTmo) tmoReg <= 1'b1;
      end
      if (stb.latchRx) rxReg <= rxWord;
      if (stb.latchRd) txReg <= memRData;
      else if (stb.loadVector) txReg <= vectorIn;
      if (stb.clrWait) waitCnt <= '0;
      else if (stb.incWait) waitCnt <= waitCnt + TMO_W'(1);
    end
  end

  assign isTx    = cmdReg[TX_BIT];
  assign subAddr = cmdReg[WC_W +: SA_W];
  assign wcField = cmdReg[WC_W-1:0];
  assign isMode  = (subAddr == '0) || (subAddr == '1);
  assign isVector = isMode && isTx && (wcField == WC_W'(MC_VECTOR));
  assign isSync   = isMode && !isTx && (wcField == WC_W'(MC_SYNC));
  assign msgErr   = isMode && illegalReg;

  assign total    = (wcField == '0) ? FULL_COUNT : {1'b0, wcField};
  assign lastWord = (idx + (WC_W+1)'(1)) == total;

  assign waitExpired = ({1'b0, waitCnt} + (TMO_W+1)'(1)) >= {1'b0, timeoutLimit};
  assign tmoFlag     = tmoReg;

  assign countField = isMode ? wcField : idx[WC_W-1:0];

  always_comb begin
    tswWord                 = '0;
    tswWord[DATA_W-1]       = 1'b1;
    tswWord[DATA_W-2]       = ~msgErr;
    tswWord[TSW_ERR_BIT]    = msgErr;
    tswWord[WC_W-1:0]       = countField;
  end

  always_comb begin
    if (stb.accOp == OP_DATA) memAddr = {isTx, subAddr, idx[WC_W-1:0]};
    else                      memAddr = {isTx, subAddr, {WC_W{1'b0}}};
  end

  always_comb begin
    case (stb.accOp)
      OP_CMD:  memWData = cmdReg;
      OP_TSW:  memWData = tswWord;
      default: memWData = rxReg;
    endcase
  end

  assign txData = txReg;

endmodule

// File: rtl/rtms_ctrl.sv
module rtms_ctrl
  import rtms_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cmdStart,
  input  logic         rxWordValid,
  input  logic         encDone,
  input  logic         memGntN,
  input  logic         writeCmd,
  input  logic         writeTsw,
  input  logic         extModeData,
  input  logic         isTx,
  input  logic         isMode,
  input  logic         isVector,
  input  logic         isSync,
  input  logic         msgErr,
  input  logic         lastWord,
  input  logic         waitExpired,
  output ctrlStrobes_t stb,
  output logic         memReqN,
  output logic         memWrite,
  output logic         statusReq,
  output logic         wordReq,
  output logic         msgDone
);

  typedef enum logic [3:0] {
    S_IDLE, S_DISPATCH, S_CMDWR, S_RXWAIT, S_RXMEM,
    S_STATUS, S_TXMEM, S_TXWORD, S_TSWWR, S_DONE
  } state_e;

  state_e state, next;
  state_e firstStep, finishStep;
  logic   inMem;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= next;
  end

  assign inMem = (state == S_CMDWR) || (state == S_RXMEM) ||
                 (state == S_TXMEM) || (state == S_TSWWR);

  always_comb begin
    if (isTx)                              firstStep = S_STATUS;
    else if (isMode && !(isSync && !msgErr)) firstStep = S_STATUS;
    else                                   firstStep = S_RXWAIT;
    finishStep = writeTsw ? S_TSWWR : S_DONE;
  end

  always_comb begin
    next      = state;
    stb       = '0;
    stb.clrWait = !inMem;
    case (state)
      S_CMDWR: stb.accOp = OP_CMD;
      S_TSWWR: stb.accOp = OP_TSW;
      default: stb.accOp = OP_DATA;
    endcase

    if (inMem && memGntN) begin
      if (waitExpired) begin
        stb.setTmo = 1'b1;
        next       = S_DONE;
      end else begin
        stb.incWait = 1'b1;
      end
    end

    case (state)
      S_IDLE: begin
        if (cmdStart) begin
          stb.latchCmd = 1'b1;
          next         = S_DISPATCH;
        end
      end
      S_DISPATCH: next = writeCmd ? S_CMDWR : firstStep;
      S_CMDWR: begin
        if (!memGntN) begin
          stb.clrWait = 1'b1;
          next        = firstStep;
        end
      end
      S_RXWAIT: begin
        if (rxWordValid) begin
          stb.latchRx = 1'b1;
          next        = (isSync && !extModeData) ? S_STATUS : S_RXMEM;
        end
      end
      S_RXMEM: begin
        if (!memGntN) begin
          stb.clrWait = 1'b1;
          stb.incIdx  = 1'b1;
          next        = (isMode || lastWord) ? S_STATUS : S_RXWAIT;
        end
      end
      S_STATUS: begin
        if (encDone) begin
          if (isTx && !isMode) begin
            next = S_TXMEM;
          end else if (isVector && !msgErr) begin
            if (extModeData) begin
              next = S_TXMEM;
            end else begin
              stb.loadVector = 1'b1;
              next           = S_TXWORD;
            end
          end else begin
            next = finishStep;
          end
        end
      end
      S_TXMEM: begin
        if (!memGntN) begin
          stb.clrWait = 1'b1;
          stb.latchRd = 1'b1;
          next        = S_TXWORD;
        end
      end
      S_TXWORD: begin
        if (encDone) begin
          if (isMode) begin
            next = finishStep;
          end else begin
            stb.incIdx = 1'b1;
            next       = lastWord ? finishStep : S_TXMEM;
          end
        end
      end
      S_TSWWR: begin
        if (!memGntN) begin
          stb.clrWait = 1'b1;
          next        = S_DONE;
        end
      end
      S_DONE:  next = S_IDLE;
      default: next = S_IDLE;
    endcase
  end

  assign memReqN   = !inMem;
  assign memWrite  = (state != S_TXMEM);
  assign statusReq = (state == S_STATUS);
  assign wordReq   = (state == S_TXWORD);
  assign msgDone   = (state == S_DONE);

endmodule

// File: rtl/rt_mem_sequencer.sv
module rt_mem_sequencer
  import rtms_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int SA_W      = 5,
  parameter int WC_W      = 5,
  parameter int TMO_W     = 16,
  parameter int MC_VECTOR = 16,
  parameter int MC_SYNC   = 17,
  localparam int ADDR_W   = 1 + SA_W + WC_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdStart,
  input  logic [DATA_W-1:0] cmdWord,
  input  logic              modeIllegal,
  input  logic              writeCmd,
  input  logic              writeTsw,
  input  logic              extModeData,
  input  logic [DATA_W-1:0] vectorIn,
  input  logic [TMO_W-1:0]  timeoutLimit,
  input  logic              rxWordValid,
  input  logic [DATA_W-1:0] rxWord,
  input  logic              encDone,
  output logic              statusReq,
  output logic              statusMsgErr,
  output logic              wordReq,
  output logic [DATA_W-1:0] txData,
  output logic              memReqN,
  input  logic              memGntN,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWrite,
  output logic [1:0]        memOp,
  output logic [DATA_W-1:0] memWData,
  input  logic [DATA_W-1:0] memRData,
  output logic              msgDone,
  output logic              memTimeout
);

  ctrlStrobes_t stb;
  logic isTx, isMode, isVector, isSync, msgErr, lastWord, waitExpired;

  rtms_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .rxWordValid(rxWordValid),
    .encDone(encDone), .memGntN(memGntN), .writeCmd(writeCmd),
    .writeTsw(writeTsw), .extModeData(extModeData), .isTx(isTx),
    .isMode(isMode), .isVector(isVector), .isSync(isSync), .msgErr(msgErr),
    .lastWord(lastWord), .waitExpired(waitExpired), .stb(stb),
    .memReqN(memReqN), .memWrite(memWrite), .statusReq(statusReq),
    .wordReq(wordReq), .msgDone(msgDone)
  );

  rtms_datapath #(
    .DATA_W(DATA_W), .SA_W(SA_W), .WC_W(WC_W), .TMO_W(TMO_W),
    .MC_VECTOR(MC_VECTOR), .MC_SYNC(MC_SYNC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .cmdWord(cmdWord),
    .modeIllegal(modeIllegal), .vectorIn(vectorIn),
    .timeoutLimit(timeoutLimit), .rxWord(rxWord), .memRData(memRData),
    .isTx(isTx), .isMode(isMode), .isVector(isVector), .isSync(isSync),
    .msgErr(msgErr), .lastWord(lastWord), .waitExpired(waitExpired),
    .tmoFlag(memTimeout), .memAddr(memAddr), .memWData(memWData),
    .txData(txData)
  );

  assign memOp        = stb.accOp;
  assign statusMsgErr = msgErr;

endmodule

// File: rtl/rtms_checker.sv
module rtms_checker #(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rstN,
  input logic              memReqN,
  input logic              memGntN,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memWrite,
  input logic [1:0]        memOp,
  input logic              statusReq,
  input logic              wordReq,
  input logic              msgDone,
  input logic              memTimeout
);

  // R2: the request is released in the cycle after a sampled grant
  p_release_after_grant_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!memReqN && !memGntN) |=> memReqN);

  // R3: encoder requests and memory requests never overlap
  p_exclusive_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({statusReq, wordReq, !memReqN}));

  // R4: reads are data accesses only
  p_read_is_data_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!memReqN && !memWrite) |-> (memOp == 2'b00));

  // R5: command and transfer status writes target the message base
  p_base_addr_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!memReqN && memOp != 2'b00) |-> (memAddr[4:0] == 5'd0 && memWrite));

  // R10: the timeout flag rises together with the end of the message
  p_timeout_done_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memTimeout) |-> msgDone);

  // R14: a pending request keeps its address and kind
  p_hold_pending_r14: assert property (@(posedge clk) disable iff (!rstN)
    (!memReqN && memGntN) |=>
      (memReqN || ($stable(memAddr) && $stable(memOp) && $stable(memWrite))));

endmodule

bind rt_mem_sequencer rtms_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .memReqN(memReqN), .memGntN(memGntN),
  .memAddr(memAddr), .memWrite(memWrite), .memOp(memOp),
  .statusReq(statusReq), .wordReq(wordReq), .msgDone(msgDone),
  .memTimeout(memTimeout)
);

// File: tb/rt_mem_sequencer_bench.sv
`timescale 1ns/1ps
module rt_mem_sequencer_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdStart = 1'b0;
  logic [15:0] cmdWord = '0;
  logic        modeIllegal = 1'b0;
  logic        writeCmd = 1'b0;
  logic        writeTsw = 1'b1;
  logic        extModeData = 1'b0;
  logic [15:0] vectorIn = 16'hBEEF;
  logic [15:0] timeoutLimit = 16'd64;
  logic        rxWordValid = 1'b0;
  logic [15:0] rxWord = '0;
  logic        encDone = 1'b0;
  logic        statusReq, statusMsgErr, wordReq, memReqN, memWrite, msgDone, memTimeout;
  logic [15:0] txData, memWData;
  logic [15:0] memRData = '0;
  logic        memGntN = 1'b1;
  logic [10:0] memAddr;
  logic [1:0]  memOp;

  rt_mem_sequencer u_rt_mem_sequencer (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .cmdWord(cmdWord),
    .modeIllegal(modeIllegal), .writeCmd(writeCmd), .writeTsw(writeTsw),
    .extModeData(extModeData), .vectorIn(vectorIn), .timeoutLimit(timeoutLimit),
    .rxWordValid(rxWordValid), .rxWord(rxWord), .encDone(encDone),
    .statusReq(statusReq), .statusMsgErr(statusMsgErr), .wordReq(wordReq),
    .txData(txData), .memReqN(memReqN), .memGntN(memGntN), .memAddr(memAddr),
    .memWrite(memWrite), .memOp(memOp), .memWData(memWData),
    .memRData(memRData), .msgDone(msgDone), .memTimeout(memTimeout)
  );

  always #4 clk = ~clk;

  int checkCount = 0;
  int passCount  = 0;
  int cyc        = 0;

  localparam int LOG_N = 96;
  logic [31:0] evLog [LOG_N];
  int evCount = 0;
  int reqLow = 0;
  int gntDelay = 2;
  int gntWait = 0;
  int encDelay = 3;
  int encCnt = 0;
  int holdViol = 0;
  logic        prevPend = 1'b0;
  logic [13:0] prevKey = '0;

  localparam logic [1:0] K_MEM = 2'd0, K_STAT = 2'd1, K_WORD = 2'd2;

  function automatic logic [15:0] pattern(input logic [10:0] a);
    return 16'h5A00 ^ {5'b0, a};
  endfunction

  function automatic logic [15:0] mkCmd(input logic tx, input logic [4:0] sa, input logic [4:0] wc);
    return {5'd1, tx, sa, wc};
  endfunction

  function automatic logic [31:0] ev(input logic [1:0] k, input logic [10:0] a,
                                     input logic w, input logic [1:0] op, input logic [15:0] d);
    return {k, a, w, op, d};
  endfunction

  task automatic logEv(input logic [31:0] e);
    if (evCount < LOG_N) evLog[evCount] = e;
    evCount++;
  endtask

  // memory model: grant after gntDelay waiting cycles, logs each granted access
  always @(negedge clk) begin
    if (!rstN) begin
      memGntN = 1'b1; gntWait = 0; prevPend = 1'b0;
    end else if (!memReqN) begin
      reqLow++;
      if (prevPend && prevKey != {memAddr, memWrite, memOp}) holdViol++;
      if (gntWait >= gntDelay) begin
        memGntN  = 1'b0;
        memRData = pattern(memAddr);
        logEv(ev(K_MEM, memAddr, memWrite, memOp, memWrite ? memWData : memRData));
        prevPend = 1'b0;
      end else begin
        memGntN  = 1'b1;
        gntWait++;
        prevPend = 1'b1;
        prevKey  = {memAddr, memWrite, memOp};
      end
    end else begin
      memGntN = 1'b1; gntWait = 0; prevPend = 1'b0;
    end
  end

  // encoder model: logs each request once, acknowledges after encDelay cycles
  always @(negedge clk) begin
    if (!rstN) begin
      encDone = 1'b0; encCnt = 0;
    end else if (encDone) begin
      encDone = 1'b0; encCnt = 0;
    end else if (statusReq || wordReq) begin
      if (encCnt == 0) begin
        if (statusReq) logEv(ev(K_STAT, 11'd0, 1'b0, 2'd0, {15'd0, statusMsgErr}));
        else           logEv(ev(K_WORD, 11'd0, 1'b0, 2'd0, txData));
      end
      if (encCnt >= encDelay) encDone = 1'b1;
      else encCnt++;
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", passCount, checkCount);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checkCount++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected below 150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checkCount++;
    if (ok) passCount++;
    else $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
  endtask

  task automatic expectEv(input int i, input logic [31:0] exp, input string req);
    logic [31:0] act;
    act = (i < evCount && i < LOG_N) ? evLog[i] : 32'hFFFFFFFF;
    check(act == exp, req, $sformatf("event %0d", i), act, exp);
  endtask

  task automatic clearLog();
    evCount = 0; reqLow = 0;
  endtask

  task automatic startMsg(input logic [15:0] cmd, input logic illegal);
    clearLog();
    @(negedge clk);
    cmdStart = 1'b1; cmdWord = cmd; modeIllegal = illegal;
    @(negedge clk);
    cmdStart = 1'b0;
  endtask

  task automatic sendRx(input logic [15:0] d);
    repeat (10) @(negedge clk);
    rxWordValid = 1'b1; rxWord = d;
    @(negedge clk);
    rxWordValid = 1'b0;
  endtask

  task automatic waitDone(input string req);
    bit seen;
    seen = 1'b0;
    for (int i = 0; i < 3000 && !seen; i++) begin
      @(negedge clk);
      if (msgDone) seen = 1'b1;
    end
    check(seen, req, "message completion", {31'd0, seen}, 32'd1);
    repeat (3) @(negedge clk);
  endtask

  task automatic testReset();
    check({memReqN, statusReq, wordReq, msgDone, memTimeout} == 5'b10000, "R1",
          "reset outputs", {27'd0, memReqN, statusReq, wordReq, msgDone, memTimeout}, 32'h10);
  endtask

  task automatic testRxData();
    writeCmd = 0; writeTsw = 1;
    startMsg(mkCmd(1'b0, 5'd5, 5'd3), 1'b0);
    sendRx(16'h1111); sendRx(16'h2222); sendRx(16'h3333);
    waitDone("R2");
    check(evCount == 5, "R2", "receive event count", evCount, 5);
    expectEv(0, ev(K_MEM, {1'b0, 5'd5, 5'd0}, 1'b1, 2'd0, 16'h1111), "R2");
    expectEv(1, ev(K_MEM, {1'b0, 5'd5, 5'd1}, 1'b1, 2'd0, 16'h2222), "R2");
    expectEv(2, ev(K_MEM, {1'b0, 5'd5, 5'd2}, 1'b1, 2'd0, 16'h3333), "R2");
    expectEv(3, ev(K_STAT, 11'd0, 1'b0, 2'd0, 16'd0), "R3");
    expectEv(4, ev(K_MEM, {1'b0, 5'd5, 5'd0}, 1'b1, 2'd2, 16'hC003), "R13");
  endtask

  task automatic testTxWithCmd();
    logic [15:0] c;
    c = mkCmd(1'b1, 5'd9, 5'd2);
    writeCmd = 1; writeTsw = 1;
    startMsg(c, 1'b0);
    waitDone("R4");
    check(evCount == 7, "R4", "transmit event count", evCount, 7);
    expectEv(0, ev(K_MEM, {1'b1, 5'd9, 5'd0}, 1'b1, 2'd1, c), "R5");
    expectEv(1, ev(K_STAT, 11'd0, 1'b0, 2'd0, 16'd0), "R4");
    expectEv(2, ev(K_MEM, {1'b1, 5'd9, 5'd0}, 1'b0, 2'd0, pattern({1'b1, 5'd9, 5'd0})), "R4");
    expectEv(3, ev(K_WORD, 11'd0, 1'b0, 2'd0, pattern({1'b1, 5'd9, 5'd0})), "R4");
    expectEv(4, ev(K_MEM, {1'b1, 5'd9, 5'd1}, 1'b0, 2'd0, pattern({1'b1, 5'd9, 5'd1})), "R4");
    expectEv(5, ev(K_WORD, 11'd0, 1'b0, 2'd0, pattern({1'b1, 5'd9, 5'd1})), "R4");
    expectEv(6, ev(K_MEM, {1'b1, 5'd9, 5'd0}, 1'b1, 2'd2, 16'hC002), "R5");
    writeCmd = 0;
  endtask

  task automatic testTx32();
    writeTsw = 1;
    startMsg(mkCmd(1'b1, 5'd3, 5'd0), 1'b0);
    waitDone("R4");
    check(evCount == 66, "R4", "32-word transmit event count", evCount, 66);
    expectEv(63, ev(K_MEM, {1'b1, 5'd3, 5'd31}, 1'b0, 2'd0, pattern({1'b1, 5'd3, 5'd31})), "R4");
    expectEv(64, ev(K_WORD, 11'd0, 1'b0, 2'd0, pattern({1'b1, 5'd3, 5'd31})), "R4");
    expectEv(65, ev(K_MEM, {1'b1, 5'd3, 5'd0}, 1'b1, 2'd2, 16'hC000), "R13");
  endtask

  task automatic testVectorLocal();
    writeTsw = 0; extModeData = 0; vectorIn = 16'hBEEF;
    startMsg(mkCmd(1'b1, 5'd0, 5'd16), 1'b0);
    waitDone("R7");
    check(evCount == 2, "R6", "no memory access without transfer status", evCount, 2);
    expectEv(0, ev(K_STAT, 11'd0, 1'b0, 2'd0, 16'd0), "R7");
    expectEv(1, ev(K_WORD, 11'd0, 1'b0, 2'd0, 16'hBEEF), "R7");
    writeTsw = 1;
  endtask

  task automatic testVectorMem();
    extModeData = 1;
    startMsg(mkCmd(1'b1, 5'd31, 5'd16), 1'b0);
    waitDone("R7");
    check(evCount == 4, "R7", "memory vector event count", evCount, 4);
    expectEv(1, ev(K_MEM, 11'h7E0, 1'b0, 2'd0, pattern(11'h7E0)), "R7");
    expectEv(2, ev(K_WORD, 11'd0, 1'b0, 2'd0, pattern(11'h7E0)), "R7");
    expectEv(3, ev(K_MEM, 11'h7E0, 1'b1, 2'd2, 16'hC010), "R13");
    extModeData = 0;
  endtask

  task automatic testSyncDiscard();
    extModeData = 0;
    startMsg(mkCmd(1'b0, 5'd0, 5'd17), 1'b0);
    sendRx(16'h4242);
    waitDone("R8");
    check(evCount == 2, "R8", "discarded sync word event count", evCount, 2);
    expectEv(0, ev(K_STAT, 11'd0, 1'b0, 2'd0, 16'd0), "R8");
    expectEv(1, ev(K_MEM, 11'h000, 1'b1, 2'd2, 16'hC011), "R8");
  endtask

  task automatic testSyncMem();
    extModeData = 1;
    startMsg(mkCmd(1'b0, 5'd31, 5'd17), 1'b0);
    sendRx(16'h1234);
    waitDone("R8");
    check(evCount == 3, "R8", "stored sync word event count", evCount, 3);
    expectEv(0, ev(K_MEM, 11'h3E0, 1'b1, 2'd0, 16'h1234), "R8");
    expectEv(1, ev(K_STAT, 11'd0, 1'b0, 2'd0, 16'd0), "R8");
    extModeData = 0;
  endtask

  task automatic testIllegalMode();
    extModeData = 1;
    startMsg(mkCmd(1'b1, 5'd0, 5'd16), 1'b1);
    waitDone("R9");
    check(evCount == 2, "R9", "illegal mode event count", evCount, 2);
    expectEv(0, ev(K_STAT, 11'd0, 1'b0, 2'd0, 16'd1), "R9");
    expectEv(1, ev(K_MEM, 11'h400, 1'b1, 2'd2, 16'h8210), "R9");
    extModeData = 0;
    modeIllegal = 0;
  endtask

  task automatic testIllegalIgnored();
    startMsg(mkCmd(1'b0, 5'd2, 5'd1), 1'b1);
    sendRx(16'h0F0F);
    waitDone("R12");
    check(evCount == 3, "R12", "data receive with illegal flag event count", evCount, 3);
    expectEv(0, ev(K_MEM, {1'b0, 5'd2, 5'd0}, 1'b1, 2'd0, 16'h0F0F), "R12");
    expectEv(1, ev(K_STAT, 11'd0, 1'b0, 2'd0, 16'd0), "R12");
    expectEv(2, ev(K_MEM, {1'b0, 5'd2, 5'd0}, 1'b1, 2'd2, 16'hC001), "R12");
    modeIllegal = 0;
  endtask

  task automatic testTimeout();
    gntDelay = 100000; timeoutLimit = 16'd5;
    startMsg(mkCmd(1'b1, 5'd4, 5'd2), 1'b0);
    waitDone("R10");
    check(reqLow == 5, "R10", "request cycles before abort", reqLow, 5);
    check(evCount == 1, "R10", "no access after abort", evCount, 1);
    check(memTimeout == 1'b1, "R10", "timeout flag", {31'd0, memTimeout}, 32'd1);
    repeat (20) @(negedge clk);
    check(memReqN == 1'b1 && evCount == 1, "R10", "stays idle after abort",
          {31'd0, memReqN}, 32'd1);
    gntDelay = 2; timeoutLimit = 16'd64;
  endtask

  task automatic testBusyIgnore();
    startMsg(mkCmd(1'b1, 5'd6, 5'd1), 1'b0);
    check(memTimeout == 1'b0, "R10", "timeout flag cleared by new command",
          {31'd0, memTimeout}, 32'd0);
    repeat (4) @(negedge clk);
    cmdStart = 1'b1; cmdWord = mkCmd(1'b0, 5'd7, 5'd2);
    @(negedge clk);
    cmdStart = 1'b0;
    waitDone("R11");
    repeat (40) @(negedge clk);
    check(evCount == 4, "R11", "second command ignored", evCount, 4);
    expectEv(1, ev(K_MEM, {1'b1, 5'd6, 5'd0}, 1'b0, 2'd0, pattern({1'b1, 5'd6, 5'd0})), "R11");
    expectEv(3, ev(K_MEM, {1'b1, 5'd6, 5'd0}, 1'b1, 2'd2, 16'hC001), "R11");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testRxData();
    testTxWithCmd();
    testTx32();
    testVectorLocal();
    testVectorMem();
    testSyncDiscard();
    testSyncMem();
    testIllegalMode();
    testIllegalIgnored();
    testTimeout();
    testBusyIgnore();
    check(holdViol == 0, "R14", "pending request held steady", holdViol, 0);
    summary();
    $finish;
  end

endmodule